// File: doc/BRIEF.md
# Block-Transfer Word Memory Slave

This block is an on-chip word memory that answers as a slave on a multiplexed, strobe-and-reply bus. A master opens a cycle by raising the cycle strobe while the shared address/data lines carry an address. It then moves data with a separate read strobe or write strobe, and the slave answers each transfer with a reply. The bus is modelled in the block's clock domain: every line is sampled on the rising clock edge, and "asserted" means logic 1.

Besides single-word cycles, the slave supports block transfers. In a block transfer, one address phase is followed by a run of data transfers at consecutive word addresses. With every reply the slave raises a capability flag that says it can accept another word in the same cycle. The master asks to continue by raising the page-select line as it removes its data strobe. This is the same line that marks an I/O-page reference during the address phase. If the flag is absent, the cycle degrades to a single transfer. The slave withholds the flag on its last word, so a run never wraps past the end of its storage.

Top module: `blkmem_slave`

## Requirements
- R1: While reset is held and after it is released, `bus_reply`, `bus_ad_oe` and `bus_blk_ok` are 0.
- R2: On a rising `bus_sync`, the slave latches all AW bits of `bus_ad_in`. It takes part in the cycle only if that byte address lies in [BASE, BASE+2*DEPTH) and `bus_page_sel` is 0 at that edge. Higher address bits are compared in full, so there is no aliasing. In all other cases no strobe in that cycle gets a reply, and memory is not changed.
- R3: A read strobe in a taken cycle gives `bus_reply`=1 and `bus_ad_oe`=1 one clock later, with `bus_ad_out` equal to the stored word.
- R4: A write strobe in a taken cycle stores `bus_ad_in[15:0]` at the current word and gives `bus_reply`=1 one clock later with `bus_ad_oe`=0.
- R5: Once the data strobe is removed, `bus_reply` and `bus_ad_oe` return to 0 one clock later.
- R6: `bus_blk_ok` is 1 together with a reply when the current word is not the last word of the memory. It is 0 with a reply on the last word, and 0 whenever `bus_reply` is 0.
- R7: If `bus_page_sel` is 1 at the clock where the strobe is seen removed, `bus_sync` is still 1 and `bus_blk_ok` was given, the next strobe in the same cycle uses the word address plus 2 bytes. No new address phase is needed.
- R8: If `bus_page_sel` is 0 when the strobe is removed, later strobes in the same cycle get no reply.
- R9: If a block continuation is requested on the last word, where no capability flag was given, later strobes in that cycle get no reply.
- R10: Dropping `bus_sync` ends the cycle at any point. A reply still up falls one clock later, and the next rising `bus_sync` starts a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sync | input | 1 | Cycle strobe; its rising edge marks the address phase |
| bus_rd_strb | input | 1 | Read data strobe |
| bus_wr_strb | input | 1 | Write data strobe |
| bus_page_sel | input | 1 | I/O-page select in the address phase; block request in the data phase |
| bus_ad_in | input | AW | Multiplexed address/data lines from the master; data on bits 15:0 |
| bus_ad_out | output | 16 | Read data toward the master |
| bus_ad_oe | output | 1 | Slave drives `bus_ad_out` |
| bus_reply | output | 1 | Transfer acknowledge |
| bus_blk_ok | output | 1 | Block capability flag, valid with reply |

## Verification
Each reply is due exactly one clock after the strobe is raised. It falls one clock after the strobe or the cycle strobe is removed. The address is latched at the edge that follows the rise of the cycle strobe. The driver changes inputs on falling clock edges and checks `bus_reply` on the very next falling edge, so a reply that is late or early by one cycle is counted as a miscompare. A monitor pops the expected item from a queue at each rising reply and compares data, output enable and the capability flag. Strobes that must be ignored are held for three clocks while the bench confirms that no reply appears, and the memory is later read back to show it was not written.

// File: rtl/blkmem_pkg.sv
// Shared definitions for the block-transfer word memory slave.
// Assumes a 16-bit data path on the multiplexed lines.
package blkmem_pkg;
    localparam int DATA_W = 16;

    // Cycle sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no cycle, waiting for rising cycle strobe
        ST_WAIT = 2'd1,   // addressed and taken, waiting for a data strobe
        ST_ACK  = 2'd2,   // reply up, waiting for strobe removal
        ST_DONE = 2'd3    // cycle not ours or finished, waiting for sync low
    } slv_state_t;
endpackage

// File: rtl/blkmem_decode.sv
// Address decoder: compares every configured address bit against the
// window [BASE, BASE + 2*DEPTH) and yields the word index inside it.
// Assumes BASE is word aligned and DEPTH >= 2.
module blkmem_decode #(
    parameter int          AW    = 22,
    parameter int unsigned BASE  = 32'h0000_1000,
    parameter int          DEPTH = 64,
    parameter int          IW    = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    localparam logic [AW:0]   WIN_LO   = (AW+1)'(BASE);
    localparam logic [AW:0]   WIN_HI   = (AW+1)'(BASE + 2 * DEPTH);
    localparam logic [AW-1:0] BASE_AW  = AW'(BASE);

    logic [AW:0]   addr_ext;
    logic [AW-1:0] offset;

    // Full-width window compare and byte-to-word offset
    always_comb begin
        addr_ext = {1'b0, addr};
        hit      = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
        offset   = addr - BASE_AW;
        idx      = IW'(offset >> 1);
    end
endmodule

// File: rtl/blkmem_store.sv
// Word array with one synchronous write port and one registered read
// port sharing a single index. Assumes write and read are never
// requested together.
module blkmem_store #(
    parameter int DEPTH = 64,
    parameter int IW    = $clog2(DEPTH),
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Array write
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Registered read data, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[idx];
    end

    a_r4_no_write_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !re);
endmodule

// File: rtl/blkmem_ctrl.sv
// Cycle sequencer: latches the address phase, runs the interlocked
// strobe/reply handshake per word, raises the block capability flag
// and advances the word index on a requested continuation.
// Assumes all bus lines are already synchronous to clk.
module blkmem_ctrl
    import blkmem_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync,
    input  logic          rd_strb,
    input  logic          wr_strb,
    input  logic          page_sel,
    input  logic          dec_hit,
    input  logic [IW-1:0] dec_idx,
    output logic          mem_we,
    output logic          mem_re,
    output logic [IW-1:0] idx,
    output logic          reply,
    output logic          ad_oe,
    output logic          blk_ok
);
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

    slv_state_t state;
    logic       sync_q;
    logic       strobe;
    logic       fire;

    // Transfer launch: taken cycle sees a data strobe
    always_comb begin
        strobe = rd_strb | wr_strb;
        fire   = (state == ST_WAIT) && sync && strobe;
        mem_re = fire && rd_strb;
        mem_we = fire && !rd_strb && wr_strb;
    end

    // Sequencer, index and registered bus outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sync_q <= 1'b0;
            idx    <= '0;
            reply  <= 1'b0;
            ad_oe  <= 1'b0;
            blk_ok <= 1'b0;
        end else begin
            sync_q <= sync;
            case (state)
                ST_IDLE: begin
                    if (sync && !sync_q) begin
                        idx   <= dec_idx;
                        state <= (dec_hit && !page_sel) ? ST_WAIT : ST_DONE;
                    end
                end
                ST_WAIT: begin
                    if (!sync) begin
                        state <= ST_IDLE;
                    end else if (strobe) begin
                        state  <= ST_ACK;
                        reply  <= 1'b1;
                        ad_oe  <= rd_strb;
                        blk_ok <= (idx != LAST_IDX);
                    end
                end
                ST_ACK: begin
                    if (!sync) begin
                        state  <= ST_IDLE;
                        reply  <= 1'b0;
                        ad_oe  <= 1'b0;
                        blk_ok <= 1'b0;
                    end else if (!strobe) begin
                        reply  <= 1'b0;
                        ad_oe  <= 1'b0;
                        blk_ok <= 1'b0;
                        if (page_sel && blk_ok) begin
                            idx   <= idx + 1'b1;
                            state <= ST_WAIT;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                default: begin
                    if (!sync) state <= ST_IDLE;
                end
            endcase
        end
    end

    // R3/R4: a reply only ever follows a data strobe
    a_r3_reply_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reply) |-> $past(strobe));
    // R5: reply withdrawn one clock after the strobe goes away
    a_r5_reply_release: assert property (@(posedge clk) disable iff (!rst_n)
        (reply && !strobe) |=> !reply);
    // R6: capability flag only with a reply
    a_r6_flag_with_reply: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ok |-> reply);
    // R3: output enable only with a reply
    a_r3_oe_with_reply: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> reply);
    // R7: a continuation moves the index by exactly one word
    a_r7_block_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && $past(state) == ST_ACK) |-> (idx == $past(idx) + 1'b1));
    // R10: losing the cycle strobe returns to idle
    a_r10_sync_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> (state == ST_IDLE));
endmodule

// File: rtl/blkmem_slave.sv
// Top of the block-transfer word memory slave: decoder, sequencer and
// word array. Assumes AW >= 16 so data fits in the low lines.
module blkmem_slave #(
    parameter int          AW    = 22,
    parameter int unsigned BASE  = 32'h0000_1000,
    parameter int          DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sync,
    input  logic          bus_rd_strb,
    input  logic          bus_wr_strb,
    input  logic          bus_page_sel,
    input  logic [AW-1:0] bus_ad_in,
    output logic [15:0]   bus_ad_out,
    output logic          bus_ad_oe,
    output logic          bus_reply,
    output logic          bus_blk_ok
);
    localparam int IW = $clog2(DEPTH);
    localparam int DW = blkmem_pkg::DATA_W;

    logic          dec_hit;
    logic [IW-1:0] dec_idx;
    logic [IW-1:0] cur_idx;
    logic          mem_we;
    logic          mem_re;

    blkmem_decode #(.AW(AW), .BASE(BASE), .DEPTH(DEPTH), .IW(IW)) decode_i (
        .addr (bus_ad_in),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    blkmem_ctrl #(.DEPTH(DEPTH), .IW(IW)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync     (bus_sync),
        .rd_strb  (bus_rd_strb),
        .wr_strb  (bus_wr_strb),
        .page_sel (bus_page_sel),
        .dec_hit  (dec_hit),
        .dec_idx  (dec_idx),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .idx      (cur_idx),
        .reply    (bus_reply),
        .ad_oe    (bus_ad_oe),
        .blk_ok   (bus_blk_ok)
    );

    blkmem_store #(.DEPTH(DEPTH), .IW(IW), .DW(DW)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .idx   (cur_idx),
        .wdata (bus_ad_in[DW-1:0]),
        .rdata (bus_ad_out)
    );
endmodule

// File: tb/blkmem_slave_tb_top.sv
// Scoreboard bench: driver tasks push expected replies, a monitor pops
// and compares them at each rising reply.
module blkmem_slave_tb_top;
    localparam int          AW    = 22;
    localparam int unsigned BASE  = 32'h0000_1000;
    localparam int          DEPTH = 64;

    typedef struct packed {
        logic        rd;
        logic [15:0] data;
        logic        blk;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sync = 1'b0;
    logic          bus_rd_strb = 1'b0;
    logic          bus_wr_strb = 1'b0;
    logic          bus_page_sel = 1'b0;
    logic [AW-1:0] bus_ad_in = '0;
    logic [15:0]   bus_ad_out;
    logic          bus_ad_oe;
    logic          bus_reply;
    logic          bus_blk_ok;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];
    logic [15:0] model [DEPTH];
    logic prev_reply = 1'b0;

    always #5 clk = ~clk;

    blkmem_slave #(.AW(AW), .BASE(BASE), .DEPTH(DEPTH)) dut_i (
        .clk, .rst_n, .bus_sync, .bus_rd_strb, .bus_wr_strb, .bus_page_sel,
        .bus_ad_in, .bus_ad_out, .bus_ad_oe, .bus_reply, .bus_blk_ok
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] waddr(input int w);
        return AW'(BASE + 2 * w);
    endfunction

    // Monitor: compare each new reply with the next expected item
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_reply && !prev_reply) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected reply", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(bus_ad_oe == e.rd, "R3", "output enable", 32'(bus_ad_oe), 32'(e.rd));
                    chk(bus_blk_ok == e.blk, "R6", "capability flag", 32'(bus_blk_ok), 32'(e.blk));
                    if (e.rd)
                        chk(bus_ad_out == e.data, "R3", "read data", 32'(bus_ad_out), 32'(e.data));
                end
            end
            prev_reply = bus_reply;
        end
    end

    task automatic begin_cycle(input logic [AW-1:0] a, input bit pg);
        @(negedge clk);
        bus_sync = 1'b1; bus_ad_in = a; bus_page_sel = pg;
        @(negedge clk);
        bus_ad_in = '0; bus_page_sel = 1'b0;
    endtask

    task automatic end_cycle();
        @(negedge clk);
        bus_sync = 1'b0; bus_rd_strb = 1'b0; bus_wr_strb = 1'b0; bus_page_sel = 1'b0;
        @(negedge clk);
    endtask

    // One handshaken word: R3/R4 latency, R5 release, R7 continuation request
    task automatic xfer(input bit rd, input int w, input logic [15:0] wd, input bit blkreq);
        exp_t e;
        e.rd = rd; e.data = rd ? model[w] : 16'h0; e.blk = (w != DEPTH - 1);
        exp_q.push_back(e);
        if (!rd) model[w] = wd;
        @(negedge clk);
        bus_rd_strb = rd; bus_wr_strb = !rd; bus_ad_in = AW'(wd); bus_page_sel = 1'b0;
        @(negedge clk);
        chk(bus_reply == 1'b1, rd ? "R3" : "R4", "reply one clock after strobe", 32'(bus_reply), 32'd1);
        bus_rd_strb = 1'b0; bus_wr_strb = 1'b0; bus_page_sel = blkreq;
        @(negedge clk);
        chk(bus_reply == 1'b0 && bus_ad_oe == 1'b0, "R5", "reply release", 32'(bus_reply), 32'd0);
    endtask

    task automatic no_reply(input bit rd, input string req);
        @(negedge clk);
        bus_rd_strb = rd; bus_wr_strb = !rd; bus_ad_in = AW'(16'hDEAD); bus_page_sel = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(bus_reply == 1'b0 && bus_ad_oe == 1'b0, req, "strobe must be ignored", 32'(bus_reply), 32'd0);
        end
        bus_rd_strb = 1'b0; bus_wr_strb = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_reply == 1'b0, "R1", "reply in reset", 32'(bus_reply), 32'd0);
        chk(bus_ad_oe == 1'b0, "R1", "oe in reset", 32'(bus_ad_oe), 32'd0);
        chk(bus_blk_ok == 1'b0, "R1", "flag in reset", 32'(bus_blk_ok), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_reply == 1'b0 && bus_blk_ok == 1'b0, "R1", "idle after reset", 32'(bus_reply), 32'd0);

        // R4/R7/R6/R9: one block write filling the whole memory
        begin_cycle(waddr(0), 1'b0);
        for (int w = 0; w < DEPTH; w++)
            xfer(1'b0, w, 16'hA500 ^ 16'(w * 16'h0103), 1'b1);
        no_reply(1'b0, "R9");
        end_cycle();

        // R3/R8: single read, then a second strobe is ignored
        begin_cycle(waddr(5), 1'b0);
        xfer(1'b1, 5, 16'h0, 1'b0);
        no_reply(1'b1, "R8");
        end_cycle();

        // R7: block read of eight words from word 10
        begin_cycle(waddr(10), 1'b0);
        for (int w = 10; w < 18; w++) xfer(1'b1, w, 16'h0, w != 17);
        end_cycle();

        // R4: single write then read back
        begin_cycle(waddr(20), 1'b0);
        xfer(1'b0, 20, 16'h5A3C, 1'b0);
        end_cycle();
        begin_cycle(waddr(20), 1'b0);
        xfer(1'b1, 20, 16'h0, 1'b0);
        end_cycle();

        // R6: block read running into the last word
        begin_cycle(waddr(60), 1'b0);
        for (int w = 60; w < DEPTH; w++) xfer(1'b1, w, 16'h0, 1'b1);
        no_reply(1'b1, "R9");
        end_cycle();

        // R2: outside window, aliases and page-select address phases
        begin_cycle(AW'(BASE - 2), 1'b0);            no_reply(1'b0, "R2"); end_cycle();
        begin_cycle(AW'(BASE + 2 * DEPTH), 1'b0);    no_reply(1'b0, "R2"); end_cycle();
        begin_cycle(AW'(BASE) | AW'(1 << 16), 1'b0); no_reply(1'b0, "R2"); end_cycle();
        begin_cycle(AW'(BASE) | AW'(1 << 21), 1'b0); no_reply(1'b0, "R2"); end_cycle();
        begin_cycle(waddr(0), 1'b1);                 no_reply(1'b0, "R2"); end_cycle();
        // R2: word 0 untouched by the ignored writes
        begin_cycle(waddr(0), 1'b0);
        xfer(1'b1, 0, 16'h0, 1'b0);
        end_cycle();

        // R10: cycle strobe dropped while reply is up
        begin_cycle(waddr(3), 1'b0);
        begin
            exp_t e;
            e.rd = 1'b1; e.data = model[3]; e.blk = 1'b1;
            exp_q.push_back(e);
        end
        @(negedge clk);
        bus_rd_strb = 1'b1;
        @(negedge clk);
        chk(bus_reply == 1'b1, "R10", "reply before sync drop", 32'(bus_reply), 32'd1);
        bus_sync = 1'b0;
        @(negedge clk);
        chk(bus_reply == 1'b0, "R10", "reply after sync drop", 32'(bus_reply), 32'd0);
        bus_rd_strb = 1'b0;
        @(negedge clk);
        // R10: fresh address phase works afterwards
        begin_cycle(waddr(7), 1'b0);
        xfer(1'b1, 7, 16'h0, 1'b0);
        end_cycle();

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "all expected replies seen", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule